// File: doc/BRIEF.md
# Dual-Channel Sample Output Multiplexer

This block is the digital back end of a two-channel (I and Q) sampling converter. On every rising clock edge it takes one 12-bit result for each channel, carries both results through matched fixed-latency delay lines and drives them onto one shared 12-bit output bus. A select input picks the channel shown on the bus. The I lane updates on rising edges. The Q lane passes through one extra falling-edge register, so it updates half a period later.

If the select input is driven by the clock itself, the bus carries I data during the high phase and Q data during the low phase. Both channels then share the bus within each period. An active-low output enable releases the bus to high impedance and lowers a separate drive-enable output. Capture and delay continue while the bus is released, so the current pipeline contents appear again as soon as the enable returns low.

A synchronous active-high reset clears both delay lines. A per-lane valid flag marks the point from which real samples reach the output.

Top module: `dual_lane_outmux`

## Requirements
- R1: While reset is high at a rising edge, every stage of both delay lines is cleared. Within one clock period the bus reads 0x000 and both valid flags are low.
- R2: Both channels are captured on the same rising edge, and the bus carries a result bit for bit, with bus bit 11 as the most significant bit. A Q value of 0x800 or above therefore shows bus bit 11 high.
- R3: A sample captured at rising edge k drives the I lane of the bus from rising edge k+7 until rising edge k+8.
- R4: A sample captured at rising edge k drives the Q lane of the bus from the falling edge that follows rising edge k+7 until the falling edge that follows rising edge k+8.
- R5: When select is high the bus shows the I lane. When select is low it shows the Q lane.
- R6: When select follows the clock, the bus shows the I sample of edge k-7 during the high phase after edge k and the Q sample of edge k-7 during the following low phase.
- R7: While output enable (active low) is high, the drive-enable output is low and the data lines are high impedance. Capture and delay continue. When the enable returns low, the bus immediately shows the data the pipeline would hold without the pause.
- R8: After reset is released, the first capture edge is edge 0. The I valid flag rises at rising edge 7 and the Q valid flag rises at the falling edge after rising edge 7. Both stay high until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; rising edge captures, falling edge updates the Q lane |
| rst | input | 1 | Synchronous active-high reset |
| smp_i_i | input | 12 | I channel conversion result |
| smp_q_i | input | 12 | Q channel conversion result |
| sel_i | input | 1 | Lane select: 1 = I, 0 = Q; may be tied to clk |
| oe_n_i | input | 1 | Active-low output enable |
| dout_o | output | 12 | Shared output bus, high impedance when disabled |
| dout_drv_o | output | 1 | High while the bus is actively driven |
| vld_i_o | output | 1 | I lane carries a sample captured after reset |
| vld_q_o | output | 1 | Q lane carries a sample captured after reset |

## Verification
The hardest situation to reach from the ports is the half-period offset between the lanes. It only shows when the bus is read in both clock phases, and it must be told apart from a full-cycle error. The stimulus therefore drives select straight from the bench clock in some segments and holds it fixed in others. It samples the bus once in each half period against a model built from the capture-edge index. Because each channel gets its own incrementing pattern, a lane swap, a missing falling-edge stage or an extra rising stage each produce a different value. A pause of the output enable inside a running stream, followed by a check against values that kept advancing, shows that the pipeline never stalled.

// File: rtl/dmx_pkg.sv
`timescale 1ns/1ps
package dmx_pkg;

    localparam int SMP_W        = 12;
    localparam int LANES        = 2;
    localparam int LAT_RISE_DEF = 7;

    typedef enum logic [0:0] {
        LANE_Q = 1'b0,
        LANE_I = 1'b1
    } lane_e;

    typedef struct packed {
        logic             vld;
        logic [SMP_W-1:0] val;
    } slot_t;

    function automatic slot_t slot_clear();
        slot_t s;
        s.vld = 1'b0;
        s.val = '0;
        return s;
    endfunction

    function automatic slot_t slot_load(input logic [SMP_W-1:0] v);
        slot_t s;
        s.vld = 1'b1;
        s.val = v;
        return s;
    endfunction

endpackage

// File: rtl/dual_capture.sv
`timescale 1ns/1ps
module dual_capture
    import dmx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] raw_i,
    input  logic [SMP_W-1:0] raw_q,
    output slot_t            cap_i,
    output slot_t            cap_q
);
    logic [SMP_W-1:0] raw [LANES];
    slot_t            held [LANES];

    assign raw[LANE_I] = raw_i;
    assign raw[LANE_Q] = raw_q;

    // Both lanes share one edge: simultaneous capture
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        slot_t r;
        always_ff @(posedge clk) begin
            if (rst) r <= slot_clear();
            else     r <= slot_load(raw[g]);
        end
        assign held[g] = r;
    end

    assign cap_i = held[LANE_I];
    assign cap_q = held[LANE_Q];
endmodule

// File: rtl/rise_delay.sv
`timescale 1ns/1ps
module rise_delay
    import dmx_pkg::*;
#(
    parameter int DEPTH = LAT_RISE_DEF
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t din,
    output slot_t dout
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_stg
        slot_t q;
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) q <= slot_clear();
                else     q <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) q <= slot_clear();
                else     q <= g_stg[g-1].q;
            end
        end
    end

    assign dout = g_stg[DEPTH-1].q;
endmodule

// File: rtl/fall_stage.sv
`timescale 1ns/1ps
module fall_stage
    import dmx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t din,
    output slot_t dout
);
    // The only negative-edge register in the block
    always_ff @(negedge clk) begin
        if (rst) dout <= slot_clear();
        else     dout <= din;
    end
endmodule

// File: rtl/lane_select.sv
`timescale 1ns/1ps
module lane_select
    import dmx_pkg::*;
(
    input  lane_e            pick,
    input  slot_t            i_slot,
    input  slot_t            q_slot,
    output logic [SMP_W-1:0] val
);
    always_comb begin
        unique case (pick)
            LANE_I:  val = i_slot.val;
            LANE_Q:  val = q_slot.val;
            default: val = '0;
        endcase
    end
endmodule

// File: rtl/dual_lane_outmux.sv
`timescale 1ns/1ps
module dual_lane_outmux
    import dmx_pkg::*;
#(
    parameter int LAT_RISE = LAT_RISE_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] smp_i_i,
    input  logic [SMP_W-1:0] smp_q_i,
    input  logic             sel_i,
    input  logic             oe_n_i,
    output wire  [SMP_W-1:0] dout_o,
    output logic             dout_drv_o,
    output logic             vld_i_o,
    output logic             vld_q_o
);
    slot_t            cap_i;
    slot_t            cap_q;
    slot_t            i_out;
    slot_t            q_dly;
    slot_t            q_out;
    lane_e            pick;
    logic [SMP_W-1:0] bus_val;

    dual_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .raw_i (smp_i_i),
        .raw_q (smp_q_i),
        .cap_i (cap_i),
        .cap_q (cap_q)
    );

    rise_delay #(.DEPTH(LAT_RISE)) u_dly_i (
        .clk  (clk),
        .rst  (rst),
        .din  (cap_i),
        .dout (i_out)
    );

    rise_delay #(.DEPTH(LAT_RISE)) u_dly_q (
        .clk  (clk),
        .rst  (rst),
        .din  (cap_q),
        .dout (q_dly)
    );

    fall_stage u_fall_q (
        .clk  (clk),
        .rst  (rst),
        .din  (q_dly),
        .dout (q_out)
    );

    assign pick = sel_i ? LANE_I : LANE_Q;

    lane_select u_sel (
        .pick   (pick),
        .i_slot (i_out),
        .q_slot (q_out),
        .val    (bus_val)
    );

    assign dout_drv_o = ~oe_n_i;
    assign dout_o     = dout_drv_o ? bus_val : {SMP_W{1'bz}};
    assign vld_i_o    = i_out.vld;
    assign vld_q_o    = q_out.vld;
endmodule

// File: rtl/dmx_chk.sv
`timescale 1ns/1ps
module dmx_chk
    import dmx_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  vld_i,
    input logic  vld_q,
    input logic  drv,
    input logic  oe_n,
    input slot_t q_pre,
    input slot_t q_fin
);
    p_rst_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!vld_i && !vld_q && q_fin.val == '0))
        else $error("reset did not clear lanes");

    p_q_tracks_chain_r4: assert property (@(posedge clk) disable iff (rst)
        q_fin == q_pre)
        else $error("falling-edge Q stage out of step");

    p_drive_off_r7: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !drv)
        else $error("bus driven while disabled");

    p_vld_i_hold_r8: assert property (@(posedge clk) disable iff (rst)
        vld_i |=> vld_i)
        else $error("I valid dropped");

    p_vld_order_r8: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> vld_i)
        else $error("Q valid ahead of I valid");
endmodule

bind dual_lane_outmux dmx_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .vld_i (vld_i_o),
    .vld_q (vld_q_o),
    .drv   (dout_drv_o),
    .oe_n  (oe_n_i),
    .q_pre (q_dly),
    .q_fin (q_out)
);

// File: tb/dual_lane_outmux_bench.sv
`timescale 1ns/1ps
module dual_lane_outmux_bench;
    logic        clk     = 1'b0;
    logic        rst     = 1'b1;
    logic        oe_n    = 1'b0;
    logic        follow  = 1'b0;
    logic        sel_fix = 1'b1;
    logic [11:0] si      = '0;
    logic [11:0] sq      = '0;
    wire         sel_w   = follow ? clk : sel_fix;
    wire  [11:0] dout;
    logic        drv;
    logic        vi;
    logic        vq;

    int n_chk = 0;
    int n_bad = 0;
    int cur   = -1;
    bit done  = 1'b0;

    dual_lane_outmux u_dual_lane_outmux (
        .clk        (clk),
        .rst        (rst),
        .smp_i_i    (si),
        .smp_q_i    (sq),
        .sel_i      (sel_w),
        .oe_n_i     (oe_n),
        .dout_o     (dout),
        .dout_drv_o (drv),
        .vld_i_o    (vi),
        .vld_q_o    (vq)
    );

    always #2.5 clk = ~clk;

    // segment: [10:9] mode (0 I fixed, 1 Q fixed, 2 select = clock), [8] oe_n, [7:0] cycles
    localparam int NSEG = 7;
    localparam logic [10:0] SEGS [NSEG] = '{
        {2'd0, 1'b0, 8'd20},
        {2'd1, 1'b0, 8'd12},
        {2'd2, 1'b0, 8'd12},
        {2'd0, 1'b1, 8'd5},
        {2'd2, 1'b0, 8'd10},
        {2'd1, 1'b1, 8'd3},
        {2'd0, 1'b0, 8'd6}
    };

    function automatic logic [11:0] iv(input int k);
        if (k < 0) return 12'h000;
        return 12'h100 + 12'(k);
    endfunction

    function automatic logic [11:0] qv(input int k);
        if (k < 0) return 12'h000;
        return 12'h800 + 12'(k);
    endfunction

    task automatic chk(input string what, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h (edge %0d)", what, act, exp, cur);
        end
    endtask

    task automatic set_mode(input int m);
        follow  = (m == 2);
        sel_fix = (m == 0);
    endtask

    task automatic check_hi();
        chk("R8 I valid (high phase)", {11'b0, vi}, {11'b0, 1'(cur >= 7)});
        chk("R8 Q valid (high phase)", {11'b0, vq}, {11'b0, 1'(cur >= 8)});
        if (oe_n) begin
            chk("R7 drive released", {11'b0, drv}, 12'h000);
        end else begin
            chk("R7 drive on", {11'b0, drv}, 12'h001);
            if (follow)       chk("R6 R2 interleave high phase I", dout, iv(cur - 7));
            else if (sel_fix) chk("R3 R5 I lane latency", dout, iv(cur - 7));
            else              chk("R4 R5 Q lane held", dout, qv(cur - 8));
        end
    endtask

    task automatic check_lo();
        chk("R8 Q valid (low phase)", {11'b0, vq}, {11'b0, 1'(cur >= 7)});
        if (oe_n) begin
            chk("R7 drive released", {11'b0, drv}, 12'h000);
        end else begin
            if (follow)       chk("R6 R2 interleave low phase Q", dout, qv(cur - 7));
            else if (sel_fix) chk("R3 R5 I lane held", dout, iv(cur - 7));
            else              chk("R4 R5 Q lane latency", dout, qv(cur - 7));
        end
    endtask

    task automatic step();
        @(posedge clk);
        cur++;
        #1;
        check_hi();
        @(negedge clk);
        #1;
        check_lo();
        si = iv(cur + 1);
        sq = qv(cur + 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1 reset bus", dout, 12'h000);
        chk("R1 reset I valid", {11'b0, vi}, 12'h000);
        chk("R1 reset Q valid", {11'b0, vq}, 12'h000);
        rst = 1'b0;
        si  = iv(0);
        sq  = qv(0);

        for (int s = 0; s < NSEG; s++) begin
            set_mode(int'(SEGS[s][10:9]));
            oe_n = SEGS[s][8];
            for (int c = 0; c < int'(SEGS[s][7:0]); c++) step();
        end

        // reset in the middle of a running stream
        set_mode(0);
        rst = 1'b1;
        repeat (2) begin
            @(posedge clk);
            @(negedge clk);
        end
        #1;
        chk("R1 mid-run reset I bus", dout, 12'h000);
        chk("R1 mid-run reset I valid", {11'b0, vi}, 12'h000);
        chk("R1 mid-run reset Q valid", {11'b0, vq}, 12'h000);
        sel_fix = 1'b0;
        #0.1;
        chk("R1 mid-run reset Q bus", dout, 12'h000);
        rst = 1'b0;
        cur = -1;
        si  = iv(0);
        sq  = qv(0);
        set_mode(2);
        repeat (10) step();

        // MSB position on the Q lane
        set_mode(1);
        step();
        chk("R2 bus bit 11 is MSB", {11'b0, dout[11]}, 12'h001);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule